// File: doc/BRIEF.md
# Time-Register Access Controller with Hold, Busy and Adjust Lockout

This block stands between a host bus and the time registers of a real-time clock, which run from seconds up to the weekday counter. It decodes host accesses and passes time-register reads and writes through to the counter side. It also owns two small control registers. The first holds a hold request, a busy status and an adjust command. The second holds a clear-the-prescaler bit and a stop bit.

The block decides the cycle in which the counter chain may advance by one second. A second boundary that arrives while the host holds the registers is stored and applied when the hold is released. While an advance is in progress, the busy status reads 1 and time-register writes are dropped. An adjust command locks out time-register writes for a fixed number of 8192 Hz ticks. A power-fail select input clears the hold and prescaler-clear bits and makes the bus deaf. An address latch, chosen by a parameter, captures the chip select and the address on a strobe so that the block can sit on a multiplexed bus.

Top module: `rtc_access_ctrl`

## Requirements
- R1: After reset, the control register (address 13) and the function register (address 15) both read 0, and `sub_clr`, `stop_o`, `inc_go` and `adj_pulse` are low.
- R2: Addresses 0 to 12 are time registers. Writes reach `tr_we`/`tr_addr`/`tr_wdata` and reads return `tr_rdata`. Address 13 is the control register: bit 0 = hold (read/write), bit 1 = busy (read-only), bit 2 = adjust (writing 1 pulses `adj_pulse` in the write cycle; reads 0), bit 3 reads 0. Address 14 reads 0 and ignores writes.
- R3: While hold is 0 and busy is 0, a `sec_carry` pulse raises `inc_go` in the same cycle.
- R4: After an `inc_go` cycle, control bit 1 (busy) reads 1 for exactly INC_CYC (default 4) cycles and then reads 0.
- R5: While hold is 1, `inc_go` stays low. Any number of carries seen during hold or busy are kept as one pending advance. That advance raises `inc_go` once, in the first cycle with hold and busy both 0.
- R6: A write of 1 to control bit 2 blocks time-register writes until LOCK_TICKS (default 625) `tick_8k` pulses have been counted. The last blocked write is the one seen after 624 ticks, and a write after 625 ticks is accepted.
- R7: A time-register write is dropped while busy is 1 and in the cycle where `inc_go` is 1. Time-register reads pass through during busy and during the lockout.
- R8: While `pf_cs` is low, `standby` is 1, no write reaches any register, and `rdata` is 0. Hold and the prescaler-clear bit are cleared to 0.
- R9: Function register bit 0 (prescaler clear) drives `sub_clr` and bit 1 drives `stop_o`. Each level stays until it is overwritten.
- R10: With MUX_BUS=1, `cs_n` and `addr_in` are captured at a clock edge with `ale` high, and accesses use the captured values even after `addr_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_cs | input | 1 | Power-fail select; low puts the block in standby |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address/select capture strobe |
| addr_in | input | AW | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Read data nibble (0 when not reading) |
| tick_8k | input | 1 | 8192 Hz enable pulse |
| sec_carry | input | 1 | One-cycle second boundary from the prescaler |
| inc_go | output | 1 | Counter chain may advance this cycle |
| tr_addr | output | AW | Time-register address |
| tr_we | output | 1 | Time-register write enable |
| tr_wdata | output | 4 | Time-register write data |
| tr_rdata | input | 4 | Time-register read data |
| adj_pulse | output | 1 | 30-second adjust command pulse |
| stop_o | output | 1 | Stop level for the prescaler |
| sub_clr | output | 1 | Prescaler clear level |
| standby | output | 1 | Bus disabled by power-fail select |

## Verification
A second boundary and a host write to a time register can land in the same cycle. This can happen directly, or when a carry stored during busy matures in the cycle the host writes. The bench sets this up by raising `sec_carry` during an increment and then holding `wr_en` high to a time address through the end of busy. It expects `inc_go` high and `tr_we` low in the cycle busy ends, and the write accepted only once the second increment has also drained. A hold release that coincides with a stored carry is checked the same way: exactly one advance, in the cycle right after the write that clears hold.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int NIB = 4;
  typedef logic [NIB-1:0] nib_t;

  // control register bit positions
  localparam int CB_HOLD = 0;
  localparam int CB_BUSY = 1;
  localparam int CB_ADJ  = 2;
  // function register bit positions
  localparam int FB_CLR  = 0;
  localparam int FB_STOP = 1;

  function automatic nib_t ctrl_word(input logic hold, input logic busy);
    nib_t w;
    w = '0;
    w[CB_HOLD] = hold;
    w[CB_BUSY] = busy;
    return w;
  endfunction

  function automatic nib_t fn_word(input logic clr, input logic stop);
    nib_t w;
    w = '0;
    w[FB_CLR]  = clr;
    w[FB_STOP] = stop;
    return w;
  endfunction
endpackage

// File: rtl/rac_addr_latch.sv
module rac_addr_latch #(
  parameter int AW      = 4,
  parameter bit MUX_BUS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          cs_n,
  input  logic [AW-1:0] addr_in,
  output logic          eff_cs_n,
  output logic [AW-1:0] eff_addr
);
  generate
    if (MUX_BUS) begin : g_latched
      logic          cs_q;
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_q   <= 1'b1;
          addr_q <= '0;
        end else if (ale) begin
          cs_q   <= cs_n;
          addr_q <= addr_in;
        end
      end
      assign eff_cs_n = cs_q;
      assign eff_addr = addr_q;
    end else begin : g_direct
      assign eff_cs_n = cs_n;
      assign eff_addr = addr_in;
    end
  endgenerate
endmodule

// File: rtl/rac_tick_gate.sv
module rac_tick_gate #(
  parameter int INC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_carry,
  input  logic hold,
  output logic inc_go,
  output logic busy
);
  localparam int BW = $clog2(INC_CYC + 1);

  logic [BW-1:0] cnt_q;
  logic          pend_q;

  assign busy   = (cnt_q != '0);
  assign inc_go = (sec_carry || pend_q) && !hold && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (inc_go)
        cnt_q <= BW'(INC_CYC);
      else if (busy)
        cnt_q <= cnt_q - BW'(1);

      if (inc_go)
        pend_q <= 1'b0;
      else if (sec_carry)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rac_lockout.sv
module rac_lockout #(
  parameter int LOCK_TICKS = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic lock
);
  localparam int CW = $clog2(LOCK_TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign lock = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CW'(LOCK_TICKS);
    else if (lock && tick)
      cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/rtc_access_ctrl.sv
module rtc_access_ctrl
  import rac_pkg::*;
#(
  parameter int AW         = 4,
  parameter int TIME_REGS  = 13,
  parameter int CTRL_ADDR  = 13,
  parameter int FN_ADDR    = 15,
  parameter int INC_CYC    = 4,
  parameter int LOCK_TICKS = 625,
  parameter bit MUX_BUS    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_cs,
  input  logic          cs_n,
  input  logic          ale,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    wdata,
  output logic [3:0]    rdata,
  input  logic          tick_8k,
  input  logic          sec_carry,
  output logic          inc_go,
  output logic [AW-1:0] tr_addr,
  output logic          tr_we,
  output logic [3:0]    tr_wdata,
  input  logic [3:0]    tr_rdata,
  output logic          adj_pulse,
  output logic          stop_o,
  output logic          sub_clr,
  output logic          standby
);
  localparam logic [AW-1:0] TIME_LAST = AW'(TIME_REGS - 1);
  localparam logic [AW-1:0] CTRL_A    = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] FN_A      = AW'(FN_ADDR);

  logic          eff_cs_n;
  logic [AW-1:0] eff_addr;
  logic          sel, is_time, is_ctrl, is_fn;
  logic          ctrl_wr, fn_wr;
  logic          hold_q, clr_q, stop_q;
  logic          busy_w, lock_w;

  rac_addr_latch #(.AW(AW), .MUX_BUS(MUX_BUS)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .addr_in(addr_in),
    .eff_cs_n(eff_cs_n), .eff_addr(eff_addr)
  );

  rac_tick_gate #(.INC_CYC(INC_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .sec_carry(sec_carry), .hold(hold_q),
    .inc_go(inc_go), .busy(busy_w)
  );

  rac_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(adj_pulse), .tick(tick_8k), .lock(lock_w)
  );

  // decode
  assign sel     = pf_cs && !eff_cs_n;
  assign is_time = (eff_addr <= TIME_LAST);
  assign is_ctrl = (eff_addr == CTRL_A);
  assign is_fn   = (eff_addr == FN_A);
  assign ctrl_wr = sel && wr_en && is_ctrl;
  assign fn_wr   = sel && wr_en && is_fn;

  // time-register path
  assign tr_addr  = eff_addr;
  assign tr_wdata = wdata;
  assign tr_we    = sel && wr_en && is_time && !busy_w && !lock_w && !inc_go;

  assign adj_pulse = ctrl_wr && wdata[CB_ADJ];
  assign standby   = !pf_cs;
  assign sub_clr   = clr_q;
  assign stop_o    = stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      clr_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (!pf_cs) begin
      hold_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (ctrl_wr) hold_q <= wdata[CB_HOLD];
      if (fn_wr) begin
        clr_q  <= wdata[FB_CLR];
        stop_q <= wdata[FB_STOP];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && rd_en) begin
      if (is_time)      rdata = tr_rdata;
      else if (is_ctrl) rdata = ctrl_word(hold_q, busy_w);
      else if (is_fn)   rdata = fn_word(clr_q, stop_q);
    end
  end
endmodule

// File: rtl/rac_chk.sv
module rac_chk (
  input logic clk,
  input logic rst_n,
  input logic pf_cs,
  input logic sec_carry,
  input logic inc_go,
  input logic tr_we,
  input logic adj_pulse,
  input logic sub_clr,
  input logic hold_q,
  input logic busy_w,
  input logic lock_w
);
  a_r3_carry_fires: assert property (@(posedge clk) disable iff (!rst_n)
    sec_carry && !hold_q && !busy_w |-> inc_go);

  a_r4_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inc_go |=> busy_w);

  a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !inc_go);

  a_r6_adj_locks: assert property (@(posedge clk) disable iff (!rst_n)
    adj_pulse |=> lock_w);

  a_r6_lock_blocks_wr: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |-> !tr_we);

  a_r7_busy_blocks_wr: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w || inc_go |-> !tr_we);

  a_r8_pf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_cs |=> !hold_q && !sub_clr);

  a_r8_pf_no_adj: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_cs |-> !adj_pulse && !tr_we);
endmodule

bind rtc_access_ctrl rac_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pf_cs(pf_cs), .sec_carry(sec_carry),
  .inc_go(inc_go), .tr_we(tr_we), .adj_pulse(adj_pulse), .sub_clr(sub_clr),
  .hold_q(hold_q), .busy_w(busy_w), .lock_w(lock_w)
);

// File: tb/rtc_access_ctrl_tb_top.sv
`timescale 1ns/100ps
module rtc_access_ctrl_tb_top;
  localparam int INC = 4;
  localparam int LCK = 625;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_cs = 1'b1, cs_n = 1'b1, ale = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr_in = '0, wdata = '0, rdata, tr_addr, tr_wdata, tr_rdata;
  logic tick_8k = 1'b0, sec_carry = 1'b0;
  logic inc_go, tr_we, adj_pulse, stop_o, sub_clr, standby;

  int total = 0, bad = 0;
  bit done = 0;
  logic s_we, s_adj, s_inc;
  logic [3:0] s_taddr, s_twd, s_rd;

  always #2.5 clk = ~clk;

  assign tr_rdata = tr_addr ^ 4'hA;

  rtc_access_ctrl #(.INC_CYC(INC), .LOCK_TICKS(LCK), .MUX_BUS(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pf_cs(pf_cs), .cs_n(cs_n), .ale(ale),
    .addr_in(addr_in), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .tick_8k(tick_8k), .sec_carry(sec_carry), .inc_go(inc_go),
    .tr_addr(tr_addr), .tr_we(tr_we), .tr_wdata(tr_wdata), .tr_rdata(tr_rdata),
    .adj_pulse(adj_pulse), .stop_o(stop_o), .sub_clr(sub_clr), .standby(standby)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic latch(input logic [3:0] a);
    nxt(); ale = 1'b1; cs_n = 1'b0; addr_in = a; wr_en = 1'b0; rd_en = 1'b0;
    nxt(); ale = 1'b0; addr_in = ~a;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    latch(a);
    wdata = d; wr_en = 1'b1;
    #1 s_we = tr_we; s_adj = adj_pulse; s_taddr = tr_addr; s_twd = tr_wdata;
    nxt(); wr_en = 1'b0; cs_n = 1'b1;
    #1 s_inc = inc_go;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    latch(a);
    rd_en = 1'b1;
    #1 s_rd = rdata;
    nxt(); rd_en = 1'b0; cs_n = 1'b1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    nxt();
    // R1 reset state
    chk("R1 sub_clr", sub_clr, 0);
    chk("R1 stop_o", stop_o, 0);
    chk("R1 inc_go", inc_go, 0);
    chk("R1 adj_pulse", adj_pulse, 0);
    bus_rd(4'd13); chk("R1 ctrl", s_rd, 0);
    bus_rd(4'd15); chk("R1 fn", s_rd, 0);

    // R2 / R10 write sweep with address changed after capture
    for (int a = 0; a < 16; a++) begin
      if (a == 13 || a == 15) continue;
      bus_wr(4'(a), 4'(a) ^ 4'h3);
      chk("R2 tr_we", s_we, (a <= 12) ? 1 : 0);
      if (a <= 12) begin
        chk("R10 tr_addr", s_taddr, a);
        chk("R2 tr_wdata", s_twd, a ^ 3);
      end
    end
    for (int a = 0; a < 15; a++) begin
      if (a == 13) continue;
      bus_rd(4'(a));
      chk("R2 rdata", s_rd, (a <= 12) ? (a ^ 10) : 0);
    end

    // R9 function register
    bus_wr(4'd15, 4'b0010);
    chk("R9 stop_o", stop_o, 1); chk("R9 sub_clr", sub_clr, 0);
    bus_wr(4'd15, 4'b0001);
    chk("R9 sub_clr set", sub_clr, 1); chk("R9 stop cleared", stop_o, 0);
    bus_rd(4'd15); chk("R9 fn read", s_rd, 1);
    repeat (5) nxt();
    chk("R9 sub_clr holds", sub_clr, 1);
    bus_wr(4'd15, 4'b0000); chk("R9 sub_clr cleared", sub_clr, 0);

    // R3 / R4 carry and busy window
    latch(4'd13);
    sec_carry = 1'b1;
    #1 chk("R3 inc_go", inc_go, 1);
    for (int k = 0; k < INC + 2; k++) begin
      nxt(); sec_carry = 1'b0; rd_en = 1'b1;
      #1 chk("R4 busy bit", rdata[1], (k < INC) ? 1 : 0);
      chk("R4 no extra inc", inc_go, 0);
    end
    nxt(); rd_en = 1'b0;

    // R7 / R5 writes during busy, carry stored during busy
    latch(4'd3);
    sec_carry = 1'b1;
    #1 chk("R3 inc_go 2", inc_go, 1);
    for (int k = 0; k < 10; k++) begin
      nxt();
      sec_carry = (k == 1);
      wdata = 4'h7; wr_en = 1'b1;
      #1;
      if (k == 4) chk("R5 pending fires", inc_go, 1);
      else chk("R5 inc_go quiet", inc_go, 0);
      chk("R7 write vs busy", tr_we, (k == 9) ? 1 : 0);
    end
    nxt(); wr_en = 1'b0; cs_n = 1'b1;
    repeat (INC + 1) nxt();

    // R5 hold defers carries to one advance
    bus_wr(4'd13, 4'b0001);
    bus_rd(4'd13); chk("R2 hold readback", s_rd, 1);
    nxt(); sec_carry = 1'b1; #1 chk("R5 held", inc_go, 0);
    nxt(); sec_carry = 1'b0;
    nxt(); sec_carry = 1'b1; #1 chk("R5 held 2", inc_go, 0);
    nxt(); sec_carry = 1'b0;
    bus_wr(4'd13, 4'b0000);
    chk("R5 release fires", s_inc, 1);
    begin
      int extra = 0;
      for (int k = 0; k < INC + 4; k++) begin
        nxt(); #1 if (inc_go) extra++;
      end
      chk("R5 single advance", extra, 0);
    end

    // R6 adjust lockout
    bus_wr(4'd13, 4'b0100);
    chk("R2 adj_pulse", s_adj, 1);
    bus_rd(4'd13); chk("R2 adj reads 0", s_rd, 0);
    for (int i = 0; i < LCK - 3; i++) begin
      nxt(); tick_8k = 1'b1;
    end
    nxt(); tick_8k = 1'b0;
    bus_wr(4'd5, 4'h9); chk("R6 locked mid", s_we, 0);
    nxt(); tick_8k = 1'b1;
    nxt(); tick_8k = 1'b1;
    nxt(); tick_8k = 1'b0;
    bus_wr(4'd5, 4'h9); chk("R6 locked at 624", s_we, 0);
    bus_rd(4'd5); chk("R7 read in lock", s_rd, 4'hF);
    nxt(); tick_8k = 1'b1;
    nxt(); tick_8k = 1'b0;
    bus_wr(4'd5, 4'h9); chk("R6 open at 625", s_we, 1);

    // R8 power-fail select
    bus_wr(4'd13, 4'b0001);
    bus_wr(4'd15, 4'b0011);
    chk("R8 pre sub_clr", sub_clr, 1);
    latch(4'd2);
    pf_cs = 1'b0; wr_en = 1'b1; wdata = 4'h6;
    #1 chk("R8 standby", standby, 1);
    chk("R8 write blocked", tr_we, 0);
    nxt(); wr_en = 1'b0; rd_en = 1'b1;
    #1 chk("R8 rdata zero", rdata, 0);
    chk("R8 sub_clr cleared", sub_clr, 0);
    nxt(); rd_en = 1'b0; pf_cs = 1'b1; cs_n = 1'b1;
    #1 chk("R8 standby off", standby, 0);
    bus_rd(4'd13); chk("R8 hold cleared", s_rd, 0);
    bus_rd(4'd15); chk("R8 stop kept", s_rd, 2);

    done = 1;
    summary();
  end
endmodule